// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Update Masks

This block is the combinational arithmetic and logic unit for an accumulator-style processor datapath. In the same evaluation it takes an operation code, the accumulator value, a memory operand and the current carry flag. It returns a result, a strobe that says whether the result should be written back, and new values for the negative (N), overflow (V), zero (Z) and carry (C) flags. Each flag has its own update bit. The surrounding register file keeps any flag whose update bit is low.

Arithmetic is pure binary, and decimal mode is not considered. Subtraction uses the inverted carry as its borrow, so a set carry means "no borrow". Compare and bit test change flags only and never request a write. Increment, decrement, shifts and rotates act on the memory operand port. An accumulator-mode shift is done by presenting the accumulator value on that port.

Top module: `alu8_core`

## Requirements
- R1: Op code 0 (add) gives result = (acc + mem + carry_in) mod 256. It writes the result, updates N, V, Z and C, and sets C when the unsigned sum exceeds 255.
- R2: Op code 1 (subtract) gives result = (acc - mem - (1 - carry_in)) mod 256. It writes the result, updates N, V, Z and C, and sets C when that difference is not negative.
- R3: Op code 2 (compare) updates only N, Z and C from acc - mem. C is set when acc >= mem and Z when acc == mem. There is no write.
- R4: Op code 6 (bit test) updates only N, V and Z. N = mem bit 7, V = mem bit 6, and Z is set when acc AND mem is zero. There is no write.
- R5: Op codes 3, 4 and 5 (AND, OR, XOR of acc and mem) write their result and update only N and Z.
- R6: Op codes 7 and 8 write mem + 1 and mem - 1 modulo 256. They update only N and Z and never update C or V.
- R7: Op code 9 (shift left) writes mem shifted left with 0 into bit 0 and sets C = mem bit 7. Op code 10 (logical shift right) writes mem shifted right with 0 into bit 7, sets C = mem bit 0, and leaves N = 0. Both update N, Z and C.
- R8: Op code 11 (rotate left) puts carry_in into bit 0 and mem bit 7 into C. Op code 12 (rotate right) puts carry_in into bit 7 and mem bit 0 into C. Both write and update N, Z and C.
- R9: For every operation that updates N and Z, N equals bit 7 of the flag source value and Z is set exactly when that value is zero. The source is the written result, the compare difference, or, for bit test, only Z from acc AND mem.
- R10: V, when updated by add or subtract, is set exactly when the signed (two's complement) result of the operation lies outside -128..127.
- R11: Op codes 13, 14 and 15 are reserved. They drive result 0, no write and no flag updates.
- R12: Whenever result_we is low, result_out is 0. Whenever a flag's update bit is low, that flag output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (0..12 defined, 13..15 reserved) |
| acc_in | input | 8 | Accumulator operand |
| mem_in | input | 8 | Memory operand |
| carry_in | input | 1 | Current carry flag |
| result_out | output | 8 | Operation result |
| result_we | output | 1 | Result write-back request |
| flag_n | output | 1 | New negative flag |
| flag_v | output | 1 | New overflow flag |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |
| upd_n | output | 1 | N update enable |
| upd_v | output | 1 | V update enable |
| upd_z | output | 1 | Z update enable |
| upd_c | output | 1 | C update enable |

## Verification
Two things are produced in the same evaluation: the result (with its write strobe) and the masked flag set. The masking can hide a correct value or pass a stale one. Every defined op code is swept over all 131072 combinations of accumulator, memory operand and carry. At each point the full output word (result, strobe, four flags and four update bits) is compared with a model written from the requirements. The directed corners are signed overflow at 0x7F + 1, a borrow at 0x00 - 1, an equal compare, and increment with carry_in high. They show that a correct flag value is suppressed exactly when its update bit is low.

// File: rtl/alu8_pkg.sv
// Package: shared operation codes and widths for the accumulator ALU.
// Assumes: op code values are fixed by the instruction decoder upstream.
package alu8_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADC = 4'd0,
        OP_SBC = 4'd1,
        OP_CMP = 4'd2,
        OP_AND = 4'd3,
        OP_ORA = 4'd4,
        OP_EOR = 4'd5,
        OP_BIT = 4'd6,
        OP_INC = 4'd7,
        OP_DEC = 4'd8,
        OP_ASL = 4'd9,
        OP_LSR = 4'd10,
        OP_ROL = 4'd11,
        OP_ROR = 4'd12
    } alu8_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } alu8_lg_e;

    // flag order in packed vectors: {N, V, Z, C}
    localparam int FLAG_CNT = 4;
    localparam int FN = 3;
    localparam int FV = 2;
    localparam int FZ = 1;
    localparam int FC = 0;

endpackage

// File: rtl/alu8_addsub.sv
// Module: binary adder with carry in/out and signed overflow.
// Assumes: the caller inverts operand b for subtraction and selects carry in.
module alu8_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] add_a,
    input  logic [WIDTH-1:0] add_b,
    input  logic             add_cin,
    output logic [WIDTH-1:0] add_sum,
    output logic             add_cout,
    output logic             add_ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] wide_sum;

    // full-width sum including carry out
    always_comb begin
        wide_sum = {1'b0, add_a} + {1'b0, add_b} + {{WIDTH{1'b0}}, add_cin};
    end

    assign add_sum  = wide_sum[MSB:0];
    assign add_cout = wide_sum[WIDTH];

    // overflow: like-signed inputs produce a sign change
    always_comb begin
        add_ovf = (add_a[MSB] == add_b[MSB]) && (add_sum[MSB] != add_a[MSB]);
    end
endmodule

// File: rtl/alu8_logic.sv
// Module: bitwise AND / OR / XOR of two operands.
// Assumes: bit test uses the AND selection.
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] lg_a,
    input  logic [WIDTH-1:0] lg_b,
    input  alu8_lg_e         lg_sel,
    output logic [WIDTH-1:0] lg_out
);
    // select one bitwise function
    always_comb begin
        case (lg_sel)
            LG_AND:  lg_out = lg_a & lg_b;
            LG_OR:   lg_out = lg_a | lg_b;
            LG_XOR:  lg_out = lg_a ^ lg_b;
            default: lg_out = '0;
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
// Module: one-bit shift or rotate through carry, left or right.
// Assumes: a non-rotating shift feeds zero into the vacated bit.
module alu8_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] sh_in,
    input  logic             sh_cin,
    input  logic             sh_left,
    input  logic             sh_rotate,
    output logic [WIDTH-1:0] sh_out,
    output logic             sh_cout
);
    localparam int MSB = WIDTH - 1;

    logic fill_bit;

    // bit entering the vacated position
    always_comb begin
        fill_bit = sh_rotate ? sh_cin : 1'b0;
    end

    // one-position move with the outgoing bit as carry
    always_comb begin
        if (sh_left) begin
            sh_out  = {sh_in[MSB-1:0], fill_bit};
            sh_cout = sh_in[MSB];
        end else begin
            sh_out  = {fill_bit, sh_in[MSB:1]};
            sh_cout = sh_in[0];
        end
    end
endmodule

// File: rtl/alu8_core.sv
// Module: accumulator ALU top; decodes the op, steers operands to the
// adder, logic unit and shifter, and builds result, write strobe and
// masked N/V/Z/C flags with per-flag update enables.
// Assumes: pure combinational, binary only; the caller holds the flag
// register and loads a flag only when its update bit is high.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [OP_W-1:0]  op_sel,
    input  logic [WIDTH-1:0] acc_in,
    input  logic [WIDTH-1:0] mem_in,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result_out,
    output logic             result_we,
    output logic             flag_n,
    output logic             flag_v,
    output logic             flag_z,
    output logic             flag_c,
    output logic             upd_n,
    output logic             upd_v,
    output logic             upd_z,
    output logic             upd_c
);
    localparam int MSB = WIDTH - 1;

    alu8_op_e op;
    assign op = alu8_op_e'(op_sel);

    logic [WIDTH-1:0] add_a, add_b, add_sum;
    logic             add_cin, add_cout, add_ovf;
    alu8_lg_e         lg_sel;
    logic [WIDTH-1:0] lg_out;
    logic             sh_left, sh_rotate, sh_cout;
    logic [WIDTH-1:0] sh_out;

    logic [WIDTH-1:0]    res_raw;
    logic [WIDTH-1:0]    zn_src;
    logic                we_raw;
    logic                bit_mode;
    logic [FLAG_CNT-1:0] flag_raw;
    logic [FLAG_CNT-1:0] flag_mask;
    logic [FLAG_CNT-1:0] flag_final;

    // adder operand steering per operation
    always_comb begin
        add_a   = acc_in;
        add_b   = mem_in;
        add_cin = carry_in;
        case (op)
            OP_SBC: begin add_b = ~mem_in; add_cin = carry_in; end
            OP_CMP: begin add_b = ~mem_in; add_cin = 1'b1; end
            OP_INC: begin add_a = mem_in; add_b = '0; add_cin = 1'b1; end
            OP_DEC: begin add_a = mem_in; add_b = '1; add_cin = 1'b0; end
            default: ;
        endcase
    end

    alu8_addsub #(.WIDTH(WIDTH)) u_add (
        .add_a   (add_a),
        .add_b   (add_b),
        .add_cin (add_cin),
        .add_sum (add_sum),
        .add_cout(add_cout),
        .add_ovf (add_ovf)
    );

    // logic-unit function select
    always_comb begin
        case (op)
            OP_ORA:  lg_sel = LG_OR;
            OP_EOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_AND;
        endcase
    end

    alu8_logic #(.WIDTH(WIDTH)) u_lg (
        .lg_a  (acc_in),
        .lg_b  (mem_in),
        .lg_sel(lg_sel),
        .lg_out(lg_out)
    );

    // shifter direction and rotate select
    always_comb begin
        sh_left   = (op == OP_ASL) || (op == OP_ROL);
        sh_rotate = (op == OP_ROL) || (op == OP_ROR);
    end

    alu8_shift #(.WIDTH(WIDTH)) u_sh (
        .sh_in    (mem_in),
        .sh_cin   (carry_in),
        .sh_left  (sh_left),
        .sh_rotate(sh_rotate),
        .sh_out   (sh_out),
        .sh_cout  (sh_cout)
    );

    // per-op result, write strobe, flag sources and update mask
    always_comb begin
        res_raw   = '0;
        zn_src    = '0;
        we_raw    = 1'b0;
        bit_mode  = 1'b0;
        flag_raw  = '0;
        flag_mask = '0;
        case (op)
            OP_ADC, OP_SBC: begin
                res_raw = add_sum; zn_src = add_sum; we_raw = 1'b1;
                flag_raw[FC] = add_cout; flag_raw[FV] = add_ovf;
                flag_mask = 4'b1111;
            end
            OP_CMP: begin
                zn_src = add_sum;
                flag_raw[FC] = add_cout;
                flag_mask = 4'b1011;
            end
            OP_AND, OP_ORA, OP_EOR: begin
                res_raw = lg_out; zn_src = lg_out; we_raw = 1'b1;
                flag_mask = 4'b1010;
            end
            OP_BIT: begin
                bit_mode = 1'b1; zn_src = lg_out;
                flag_raw[FV] = mem_in[MSB-1];
                flag_mask = 4'b1110;
            end
            OP_INC, OP_DEC: begin
                res_raw = add_sum; zn_src = add_sum; we_raw = 1'b1;
                flag_mask = 4'b1010;
            end
            OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
                res_raw = sh_out; zn_src = sh_out; we_raw = 1'b1;
                flag_raw[FC] = sh_cout;
                flag_mask = 4'b1011;
            end
            default: ;
        endcase
        flag_raw[FZ] = (zn_src == '0);
        flag_raw[FN] = bit_mode ? mem_in[MSB] : zn_src[MSB];
    end

    // gate each flag by its own update enable
    for (genvar gi = 0; gi < FLAG_CNT; gi++) begin : g_flag
        assign flag_final[gi] = flag_raw[gi] & flag_mask[gi];
    end

    assign result_out = res_raw;
    assign result_we  = we_raw;
    assign flag_n = flag_final[FN];
    assign flag_v = flag_final[FV];
    assign flag_z = flag_final[FZ];
    assign flag_c = flag_final[FC];
    assign upd_n  = flag_mask[FN];
    assign upd_v  = flag_mask[FV];
    assign upd_z  = flag_mask[FZ];
    assign upd_c  = flag_mask[FC];

    // guards on the decoded outputs
    always_comb begin
        if (op == OP_ADC && acc_in[MSB] == mem_in[MSB])
            a_r10_add_overflow: assert (flag_v == (result_out[MSB] != acc_in[MSB]))
                else $error("a_r10_add_overflow");
        if (op == OP_CMP)
            a_r3_cmp_no_write: assert (!result_we && !upd_v && upd_c && flag_z == (acc_in == mem_in))
                else $error("a_r3_cmp_no_write");
        if (op == OP_BIT)
            a_r4_bit_copy: assert (!result_we && flag_n == mem_in[MSB] && flag_v == mem_in[MSB-1] && !upd_c)
                else $error("a_r4_bit_copy");
        if (op == OP_INC || op == OP_DEC)
            a_r6_incdec_carry: assert (result_we && !upd_c && !upd_v)
                else $error("a_r6_incdec_carry");
        if (op == OP_LSR)
            a_r7_lsr_n_clear: assert (!flag_n && flag_c == mem_in[0])
                else $error("a_r7_lsr_n_clear");
        a_r12_flag_gated: assert (!(flag_n && !upd_n) && !(flag_v && !upd_v) &&
                                  !(flag_z && !upd_z) && !(flag_c && !upd_c))
            else $error("a_r12_flag_gated");
        a_r12_result_gated: assert (result_we || result_out == '0)
            else $error("a_r12_result_gated");
    end
endmodule

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] mem_in = '0;
    logic       carry_in = 1'b0;
    logic [7:0] result_out;
    logic       result_we, flag_n, flag_v, flag_z, flag_c;
    logic       upd_n, upd_v, upd_z, upd_c;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alu8_core u0 (
        .op_sel(op_sel), .acc_in(acc_in), .mem_in(mem_in), .carry_in(carry_in),
        .result_out(result_out), .result_we(result_we),
        .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c),
        .upd_n(upd_n), .upd_v(upd_v), .upd_z(upd_z), .upd_c(upd_c)
    );

    // reference: {result, we, N, V, Z, C, uN, uV, uZ, uC}
    function automatic logic [16:0] model(input int op, input int a, input int m, input int c);
        int r, zs, sa, sm, sr;
        logic we, n, v, z, cy, un, uv, uz, uc;
        r = 0; zs = 0; we = 0; v = 0; cy = 0; un = 0; uv = 0; uz = 0; uc = 0;
        sa = (a > 127) ? a - 256 : a;
        sm = (m > 127) ? m - 256 : m;
        case (op)
            0: begin r = (a + m + c) % 256; cy = (a + m + c) > 255; sr = sa + sm + c;
                     v = (sr > 127) || (sr < -128); we = 1; {un,uv,uz,uc} = 4'b1111; zs = r; end
            1: begin r = (a - m - (1 - c) + 512) % 256; cy = (a - m - (1 - c)) >= 0;
                     sr = sa - sm - (1 - c); v = (sr > 127) || (sr < -128);
                     we = 1; {un,uv,uz,uc} = 4'b1111; zs = r; end
            2: begin zs = (a - m + 256) % 256; cy = a >= m; {un,uv,uz,uc} = 4'b1011; end
            3: begin r = a & m; we = 1; {un,uv,uz,uc} = 4'b1010; zs = r; end
            4: begin r = a | m; we = 1; {un,uv,uz,uc} = 4'b1010; zs = r; end
            5: begin r = a ^ m; we = 1; {un,uv,uz,uc} = 4'b1010; zs = r; end
            6: begin zs = a & m; v = m[6]; {un,uv,uz,uc} = 4'b1110; end
            7: begin r = (m + 1) % 256; we = 1; {un,uv,uz,uc} = 4'b1010; zs = r; end
            8: begin r = (m + 255) % 256; we = 1; {un,uv,uz,uc} = 4'b1010; zs = r; end
            9: begin r = (m * 2) % 256; cy = m >= 128; we = 1; {un,uv,uz,uc} = 4'b1011; zs = r; end
            10: begin r = m / 2; cy = m % 2; we = 1; {un,uv,uz,uc} = 4'b1011; zs = r; end
            11: begin r = (m * 2 + c) % 256; cy = m >= 128; we = 1; {un,uv,uz,uc} = 4'b1011; zs = r; end
            12: begin r = m / 2 + c * 128; cy = m % 2; we = 1; {un,uv,uz,uc} = 4'b1011; zs = r; end
            default: ;
        endcase
        n = (op == 6) ? m[7] : zs[7];
        z = (zs == 0);
        model = {r[7:0], we, n & un, v & uv, z & uz, cy & uc, un, uv, uz, uc};
    endfunction

    task automatic apply(input int op, input int a, input int m, input int c);
        op_sel = op[3:0]; acc_in = a[7:0]; mem_in = m[7:0]; carry_in = c[0];
        #0.01;
    endtask

    task automatic check_pt(input string req, input int op, input int a, input int m, input int c);
        logic [16:0] got, exp;
        apply(op, a, m, c);
        exp = model(op, a, m, c);
        got = {result_out, result_we, flag_n, flag_v, flag_z, flag_c, upd_n, upd_v, upd_z, upd_c};
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s op=%0d a=%02h m=%02h c=%0d actual=%05h expected=%05h",
                     req, op, a, m, c, got, exp);
        end
    endtask

    task automatic sweep(input string req, input int op);
        for (int a = 0; a < 256; a++)
            for (int m = 0; m < 256; m++)
                for (int c = 0; c < 2; c++)
                    check_pt(req, op, a, m, c);
    endtask

    task automatic expect_bits(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
        end
    endtask

    task automatic t_idle();   // R11 R12: reserved codes after reset
        for (int op = 13; op < 16; op++)
            for (int a = 0; a < 256; a += 17) check_pt("R11", op, a, 255 - a, a % 2);
    endtask
    task automatic t_add();    // R1 R9 R10
        apply(0, 8'h7F, 8'h01, 0);
        expect_bits("R10", {result_out, flag_n, flag_v, flag_z, flag_c, 2'b00}, {8'h80, 4'b1100, 2'b00});
        sweep("R1", 0);
    endtask
    task automatic t_sub();    // R2 R10
        apply(1, 8'h00, 8'h01, 1);
        expect_bits("R2", {result_out, flag_n, flag_v, flag_z, flag_c, 2'b00}, {8'hFF, 4'b1000, 2'b00});
        sweep("R2", 1);
    endtask
    task automatic t_cmp();    // R3 R9
        apply(2, 8'h42, 8'h42, 0);
        expect_bits("R3", {result_out, result_we, flag_z, flag_c, upd_v, 4'h0}, {8'h00, 4'b0110, 4'h0});
        sweep("R3", 2);
    endtask
    task automatic t_logic();  // R5
        sweep("R5", 3); sweep("R5", 4); sweep("R5", 5);
    endtask
    task automatic t_bit();    // R4
        sweep("R4", 6);
    endtask
    task automatic t_incdec(); // R6 R12
        apply(7, 8'h00, 8'hFF, 1);
        expect_bits("R6", {result_out, flag_z, flag_c, upd_c, 5'b0}, {8'h00, 3'b100, 5'b0});
        sweep("R6", 7); sweep("R6", 8);
    endtask
    task automatic t_shift();  // R7
        sweep("R7", 9); sweep("R7", 10);
    endtask
    task automatic t_rotate(); // R8
        apply(12, 8'h00, 8'h01, 1);
        expect_bits("R8", {result_out, flag_n, flag_c, 6'b0}, {8'h80, 2'b11, 6'b0});
        sweep("R8", 11); sweep("R8", 12);
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (!done && cycles > 150000) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=150000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_idle();
        t_add();
        t_sub();
        t_cmp();
        t_logic();
        t_bit();
        t_incdec();
        t_shift();
        t_rotate();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule